// File: doc/BRIEF.md
# Programmable-Radix Nibble Add Unit

This unit is the execute stage for a family of memory add-with-carry operations on a 4-bit processor. Each 13-bit opcode selects one of two 16-bit index registers and an addend, which is either the B register or zero. The forms that add B also post-increment the chosen index. The unit reads one nibble from data memory and adds the addend and the carry flag. It corrects the sum to a radix from 1 to 16, writes the nibble back and updates the carry and zero flags.

The radix comes from the low opcode field, which holds sixteen minus the radix. This lets the same instruction step decimal, hexadecimal or any other counter digit by digit. The carry-only forms may follow an extension prefix that carries an 8-bit immediate. The prefix steers the access to a fixed 256-nibble page: the low page for the X form and the top page for the Y form. Completion is signalled by `done`. The prefix logic outside the unit uses that pulse as its cue to clear the extension flag. The post-increment result goes back to the register file as a write strobe plus a value.

Top module: `nibble_radix_adder`

## Requirements
- R1: Four opcode groups are accepted: bits [12:4] = 0x1D5 (X index, add B, post-increment), 0x1D7 (Y index, add B, post-increment), 0x1D0 (X index, add zero), 0x1D2 (Y index, add zero). For any other opcode, `illegal` is high for the one cycle after the accepting edge, and no memory access, flag change or index strobe follows.
- R2: Opcode bits [3:0] hold 16 minus the radix: field 0x0 selects radix 16 and field 0xF selects radix 1.
- R3: With s = memory nibble + addend + carry flag, the nibble written is s when s is below the radix and s minus the radix otherwise. Only its low four bits are kept.
- R4: The carry flag becomes 1 when s is at least the radix and 0 otherwise. The carry added is the flag left by the previous operation, and it is 0 after reset.
- R5: The zero flag becomes 1 exactly when the written nibble is 0.
- R6: The post-increment forms pulse the write strobe of the index they used (`x_wr` or `y_wr`, never both) together with `done`. `idx_wdata` then holds that index plus one, and 0xFFFF wraps to 0x0000. The increment plays no part in the flags.
- R7: The carry-only forms never pulse `x_wr` or `y_wr`.
- R8: For the carry-only forms with `ext_valid` high at acceptance, the X form accesses 0x0000 + imm and the Y form accesses 0xFF00 + imm.
- R9: The B-addend forms ignore `ext_valid` and `ext_imm`, and always access the index register's value.
- R10: If `start` is accepted at edge k, `mem_re` is high between k and k+1, `mem_we` between k+1 and k+2, and `done` with the new flags between k+2 and k+3. `start` is ignored while an operation is in flight.
- R11: After reset, `done`, `illegal`, `mem_re`, `mem_we`, `x_wr`, `y_wr` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the opcode this cycle |
| opcode | input | 13 | Instruction word |
| x_in | input | 16 | X index register value |
| y_in | input | 16 | Y index register value |
| b_in | input | 4 | B register value |
| ext_valid | input | 1 | Extension prefix is pending |
| ext_imm | input | 8 | Immediate held by the prefix |
| mem_addr | output | 16 | Data memory address |
| mem_re | output | 1 | Read request; data is due the next cycle |
| mem_rdata | input | 4 | Read data from synchronous memory |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 4 | Write data |
| x_wr | output | 1 | Write strobe for the X register |
| y_wr | output | 1 | Write strobe for the Y register |
| idx_wdata | output | 16 | Incremented index value |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | Operation complete; the extension flag is to be cleared |
| illegal | output | 1 | Opcode outside the accepted groups |

## Verification
An accepted opcode produces its read one cycle after the accepting edge, its write one cycle after the read, and `done` with flags and index strobe one cycle after the write. An illegal opcode shows only `illegal`, in the first of those cycles. The driver pushes the expected address, nibble, flags and index result into a queue before raising `start`. The monitor samples on falling edges and compares each read, write and completion against the head of the queue. It also insists that each write directly follows a read and that each `done` directly follows a write. The directed checks for illegal opcodes and for a held `start` sample at fixed falling edges counted from the accepting edge.

// File: rtl/nra_pkg.sv
package nra_pkg;
  localparam int NIB_W = 4;
  localparam int OPC_W = 13;
  localparam int GRP_W = OPC_W - NIB_W;

  localparam logic [GRP_W-1:0] GRP_X_ADDB = 9'h1D5;
  localparam logic [GRP_W-1:0] GRP_Y_ADDB = 9'h1D7;
  localparam logic [GRP_W-1:0] GRP_X_CARRY = 9'h1D0;
  localparam logic [GRP_W-1:0] GRP_Y_CARRY = 9'h1D2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } nra_state_t;

  typedef struct packed {
    logic             legal;
    logic             use_y;
    logic             use_b;
    logic             post_inc;
    logic [NIB_W-1:0] rfield;
  } nra_dec_t;
endpackage

// File: rtl/nra_decode.sv
module nra_decode
  import nra_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output nra_dec_t         dec
);
  always_comb begin
    dec        = '0;
    dec.rfield = opcode[NIB_W-1:0];
    case (opcode[OPC_W-1:NIB_W])
      GRP_X_ADDB: begin
        dec.legal    = 1'b1;
        dec.use_b    = 1'b1;
        dec.post_inc = 1'b1;
      end
      GRP_Y_ADDB: begin
        dec.legal    = 1'b1;
        dec.use_y    = 1'b1;
        dec.use_b    = 1'b1;
        dec.post_inc = 1'b1;
      end
      GRP_X_CARRY: begin
        dec.legal = 1'b1;
      end
      GRP_Y_CARRY: begin
        dec.legal = 1'b1;
        dec.use_y = 1'b1;
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/nra_addr_gen.sv
module nra_addr_gen
  import nra_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 8
) (
  input  nra_dec_t          dec,
  input  logic [ADDR_W-1:0] x_val,
  input  logic [ADDR_W-1:0] y_val,
  input  logic              ext_valid,
  input  logic [IMM_W-1:0]  ext_imm,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] idx_val
);
  localparam int PAGE_W = ADDR_W - IMM_W;

  logic page_hit;

  always_comb begin
    idx_val  = dec.use_y ? y_val : x_val;
    // the prefix only steers the carry-only forms
    page_hit = ext_valid && !dec.use_b;
    addr     = page_hit ? {{PAGE_W{dec.use_y}}, ext_imm} : idx_val;
  end
endmodule

// File: rtl/nra_radix_alu.sv
module nra_radix_alu
  import nra_pkg::*;
(
  input  logic [NIB_W-1:0] op_a,
  input  logic [NIB_W-1:0] op_b,
  input  logic             cin,
  input  logic [NIB_W-1:0] rfield,
  output logic [NIB_W-1:0] res,
  output logic             cout,
  output logic             zero
);
  localparam int SW = NIB_W + 1;

  logic [SW-1:0] radix;
  logic [SW-1:0] sum;
  logic [SW-1:0] diff;
  logic          diff_unused;

  always_comb begin
    radix = {1'b1, {NIB_W{1'b0}}} - {1'b0, rfield};
    sum   = {1'b0, op_a} + {1'b0, op_b} + {{NIB_W{1'b0}}, cin};
    diff  = sum - radix;
    cout  = (sum >= radix);
    res   = cout ? diff[NIB_W-1:0] : sum[NIB_W-1:0];
    zero  = (res == '0);
  end

  assign diff_unused = diff[NIB_W];
endmodule

// File: rtl/nibble_radix_adder.sv
module nibble_radix_adder
  import nra_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [12:0]       opcode,
  input  logic [ADDR_W-1:0] x_in,
  input  logic [ADDR_W-1:0] y_in,
  input  logic [3:0]        b_in,
  input  logic              ext_valid,
  input  logic [IMM_W-1:0]  ext_imm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  input  logic [3:0]        mem_rdata,
  output logic              mem_we,
  output logic [3:0]        mem_wdata,
  output logic              x_wr,
  output logic              y_wr,
  output logic [ADDR_W-1:0] idx_wdata,
  output logic              flag_c,
  output logic              flag_z,
  output logic              done,
  output logic              illegal
);
  nra_state_t        state;
  nra_dec_t          dec;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] acc_idx;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] idx_q;
  logic [NIB_W-1:0]  b_q;
  logic [NIB_W-1:0]  rfield_q;
  logic              use_y_q;
  logic              use_b_q;
  logic              inc_q;

  logic [NIB_W-1:0]  addend;
  logic [NIB_W-1:0]  alu_res;
  logic              alu_cout;
  logic              alu_zero;
  logic [NIB_W:0]    radix_w;

  nra_decode u_decode (
    .opcode (opcode),
    .dec    (dec)
  );

  nra_addr_gen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_addr (
    .dec       (dec),
    .x_val     (x_in),
    .y_val     (y_in),
    .ext_valid (ext_valid),
    .ext_imm   (ext_imm),
    .addr      (acc_addr),
    .idx_val   (acc_idx)
  );

  assign addend = use_b_q ? b_q : '0;

  nra_radix_alu u_alu (
    .op_a   (mem_rdata),
    .op_b   (addend),
    .cin    (flag_c),
    .rfield (rfield_q),
    .res    (alu_res),
    .cout   (alu_cout),
    .zero   (alu_zero)
  );

  assign radix_w   = {1'b1, {NIB_W{1'b0}}} - {1'b0, rfield_q};
  assign mem_addr  = addr_q;
  assign mem_re    = (state == ST_READ);
  assign mem_we    = (state == ST_WRITE);
  assign mem_wdata = alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      idx_q     <= '0;
      b_q       <= '0;
      rfield_q  <= '0;
      use_y_q   <= 1'b0;
      use_b_q   <= 1'b0;
      inc_q     <= 1'b0;
      x_wr      <= 1'b0;
      y_wr      <= 1'b0;
      idx_wdata <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= 1'b0;
      x_wr    <= 1'b0;
      y_wr    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (dec.legal) begin
              addr_q   <= acc_addr;
              idx_q    <= acc_idx;
              b_q      <= b_in;
              rfield_q <= dec.rfield;
              use_y_q  <= dec.use_y;
              use_b_q  <= dec.use_b;
              inc_q    <= dec.post_inc;
              state    <= ST_READ;
            end else begin
              illegal <= 1'b1;
            end
          end
        end
        ST_READ: begin
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          flag_c    <= alu_cout;
          flag_z    <= alu_zero;
          done      <= 1'b1;
          x_wr      <= inc_q && !use_y_q;
          y_wr      <= inc_q && use_y_q;
          idx_wdata <= idx_q + 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> mem_we);

  // R10
  wr_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done);

  // R1
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!mem_re && !mem_we && !done));

  // R4
  no_carry_below_radix_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !flag_c) |-> ({1'b0, $past(mem_wdata)} < radix_w));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_z == ($past(mem_wdata) == '0)));

  // R6
  idx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (x_wr || y_wr) |-> (done && !(x_wr && y_wr)));
endmodule

// File: tb/nibble_radix_adder_tb_top.sv
`timescale 1ns/1ps
module nibble_radix_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [12:0] opcode = '0;
  logic [15:0] x_in = '0;
  logic [15:0] y_in = '0;
  logic [3:0]  b_in = '0;
  logic        ext_valid = 1'b0;
  logic [7:0]  ext_imm = '0;
  logic [15:0] mem_addr;
  logic        mem_re;
  logic [3:0]  mem_rdata = '0;
  logic        mem_we;
  logic [3:0]  mem_wdata;
  logic        x_wr;
  logic        y_wr;
  logic [15:0] idx_wdata;
  logic        flag_c;
  logic        flag_z;
  logic        done;
  logic        illegal;

  always #4 clk = ~clk;

  nibble_radix_adder dut_i (
    .clk (clk), .rst (rst), .start (start), .opcode (opcode),
    .x_in (x_in), .y_in (y_in), .b_in (b_in),
    .ext_valid (ext_valid), .ext_imm (ext_imm),
    .mem_addr (mem_addr), .mem_re (mem_re), .mem_rdata (mem_rdata),
    .mem_we (mem_we), .mem_wdata (mem_wdata),
    .x_wr (x_wr), .y_wr (y_wr), .idx_wdata (idx_wdata),
    .flag_c (flag_c), .flag_z (flag_z), .done (done), .illegal (illegal)
  );

  logic [3:0] dmem [logic [15:0]];
  logic [3:0] ref_mem [logic [15:0]];

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= dmem.exists(mem_addr) ? dmem[mem_addr] : 4'h0;
    if (mem_we) dmem[mem_addr] = mem_wdata;
  end

  typedef struct {
    logic [15:0] addr;
    logic [3:0]  wdata;
    logic        c;
    logic        z;
    logic        xw;
    logic        yw;
    logic [15:0] idx;
    bit          ext_path;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   model_c = 1'b0;
  bit   prev_re = 1'b0;
  bit   prev_we = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [3:0] v);
    dmem[a] = v;
    ref_mem[a] = v;
  endtask

  // monitor: falling-edge sampling against the head of the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_re) begin
        if (exp_q.size() == 0) chk(1'b0, "R10 read without issue", 1, 0);
        else chk(mem_addr == exp_q[0].addr, exp_q[0].ext_path ? "R8 page address" : "R9 index address",
                 mem_addr, exp_q[0].addr);
      end
      if (mem_we) begin
        chk(prev_re, "R10 write follows read", prev_re, 1);
        if (exp_q.size() != 0) begin
          chk(mem_addr == exp_q[0].addr, "R3 write address", mem_addr, exp_q[0].addr);
          chk(mem_wdata == exp_q[0].wdata, "R3 written nibble", mem_wdata, exp_q[0].wdata);
        end
      end
      if (done) begin
        chk(prev_we, "R10 done follows write", prev_we, 1);
        if (exp_q.size() == 0) chk(1'b0, "R10 done without issue", 1, 0);
        else begin
          chk(flag_c == exp_q[0].c, "R4 carry flag", flag_c, exp_q[0].c);
          chk(flag_z == exp_q[0].z, "R5 zero flag", flag_z, exp_q[0].z);
          chk(x_wr == exp_q[0].xw && y_wr == exp_q[0].yw, exp_q[0].xw || exp_q[0].yw ?
              "R6 index strobe" : "R7 no index strobe", {x_wr, y_wr}, {exp_q[0].xw, exp_q[0].yw});
          if (exp_q[0].xw || exp_q[0].yw)
            chk(idx_wdata == exp_q[0].idx, "R6 incremented index", idx_wdata, exp_q[0].idx);
          void'(exp_q.pop_front());
        end
      end
      prev_re = mem_re;
      prev_we = mem_we;
    end
  end

  task automatic issue(input logic [12:0] op, input logic [15:0] x, input logic [15:0] y,
                       input logic [3:0] b, input bit ev, input logic [7:0] imm, input bit hold);
    exp_t e;
    bit use_y;
    bit use_b;
    int radix;
    int s;
    int m;
    use_y = op[5];
    use_b = op[6];
    e.ext_path = !use_b && ev;
    if (e.ext_path) e.addr = use_y ? {8'hFF, imm} : {8'h00, imm};
    else e.addr = use_y ? y : x;
    radix = 16 - int'(op[3:0]);
    m = ref_mem.exists(e.addr) ? int'(ref_mem[e.addr]) : 0;
    s = m + (use_b ? int'(b) : 0) + int'(model_c);
    if (s >= radix) begin
      e.wdata = 4'((s - radix) % 16);
      e.c = 1'b1;
    end else begin
      e.wdata = 4'(s);
      e.c = 1'b0;
    end
    e.z = (e.wdata == 4'h0);
    e.xw = use_b && !use_y;
    e.yw = use_b && use_y;
    e.idx = (use_y ? y : x) + 16'd1;
    model_c = e.c;
    ref_mem[e.addr] = e.wdata;
    exp_q.push_back(e);
    @(negedge clk);
    opcode = op; x_in = x; y_in = y; b_in = b; ext_valid = ev; ext_imm = imm;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic issue_bad(input logic [12:0] op);
    bit c0;
    bit z0;
    c0 = flag_c;
    z0 = flag_z;
    @(negedge clk);
    opcode = op; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(illegal == 1'b1, "R1 illegal pulse", illegal, 1);
    chk(mem_re == 1'b0, "R1 no read on illegal", mem_re, 0);
    @(negedge clk);
    chk(illegal == 1'b0, "R1 illegal one cycle", illegal, 0);
    chk(mem_re == 1'b0 && mem_we == 1'b0, "R1 no access on illegal", {mem_re, mem_we}, 0);
    @(negedge clk);
    chk(done == 1'b0 && x_wr == 1'b0 && y_wr == 1'b0, "R1 no completion on illegal",
        {done, x_wr, y_wr}, 0);
    chk(flag_c == c0 && flag_z == z0, "R1 flags kept on illegal", {flag_c, flag_z}, {c0, z0});
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "R10 watchdog expired", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    put(16'h0040, 4'd7);
    put(16'h1234, 4'd9);
    put(16'h003C, 4'hF);
    put(16'hFF81, 4'd3);
    put(16'hFFFF, 4'd2);
    put(16'h0100, 4'd0);
    put(16'h0101, 4'd0);
    put(16'h0300, 4'd4);
    for (int i = 0; i < 16; i++) begin
      put(16'h0200 + 16'(i), 4'($urandom_range(15)));
      put(16'h0000 + 16'(i), 4'($urandom_range(15)));
      put(16'hFF00 + 16'(i), 4'($urandom_range(15)));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({done, illegal, mem_re, mem_we, x_wr, y_wr, flag_c, flag_z} == 8'h00,
        "R11 reset outputs", {done, illegal, mem_re, mem_we, x_wr, y_wr, flag_c, flag_z}, 0);

    // radix 10, X + B: 7 + 5 + 0 = 12 -> 2, carry
    issue(13'h1D56, 16'h0040, 16'h0000, 4'd5, 1'b0, 8'h00, 1'b0);
    chk(flag_c == 1'b1, "R2 radix ten from field 6", flag_c, 1);
    // radix 10, Y carry-only: 9 + 0 + 1 = 10 -> 0, carry, zero
    issue(13'h1D26, 16'h0000, 16'h1234, 4'd9, 1'b0, 8'h00, 1'b0);
    // X carry-only with prefix, radix 16: 15 + 1 = 16 -> 0, carry
    issue(13'h1D00, 16'h5555, 16'h0000, 4'd0, 1'b1, 8'h3C, 1'b0);
    chk(flag_c == 1'b1 && flag_z == 1'b1, "R2 radix sixteen from field 0", {flag_c, flag_z}, 2'b11);
    // Y carry-only with prefix: 3 + 1 = 4
    issue(13'h1D20, 16'h0000, 16'h7777, 4'd0, 1'b1, 8'h81, 1'b0);
    // Y + B ignores prefix, radix 6, wrap of Y: 2 + 3 = 5
    issue(13'h1D7A, 16'h0000, 16'hFFFF, 4'd3, 1'b1, 8'h10, 1'b0);
    chk(idx_wdata == 16'h0000, "R6 wrap to zero", idx_wdata, 0);
    // radix 1: 0 + 0 + 0 = 0 stays, no carry
    issue(13'h1D5F, 16'h0100, 16'h0000, 4'd0, 1'b0, 8'h00, 1'b0);
    chk(flag_c == 1'b0, "R2 radix one below", flag_c, 0);
    // radix 1: 0 + 1 + 0 = 1 -> 0, carry
    issue(13'h1D5F, 16'h0101, 16'h0000, 4'd1, 1'b0, 8'h00, 1'b0);
    chk(flag_c == 1'b1, "R2 radix one carry", flag_c, 1);

    issue_bad(13'h1D10);
    issue_bad(13'h1C50);

    // start held over the busy cycles must yield one operation only
    issue(13'h1D56, 16'h0300, 16'h0000, 4'd2, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    chk(mem_re == 1'b0, "R10 start ignored while busy", mem_re, 0);

    for (int n = 0; n < 60; n++) begin
      logic [12:0] op;
      case ($urandom_range(3))
        0: op = 13'h1D50;
        1: op = 13'h1D70;
        2: op = 13'h1D00;
        default: op = 13'h1D20;
      endcase
      op[3:0] = 4'($urandom_range(15));
      issue(op, 16'h0200 + 16'($urandom_range(15)), 16'h0200 + 16'($urandom_range(15)),
            4'($urandom_range(15)), 1'($urandom_range(1)), 8'($urandom_range(15)), 1'b0);
    end

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule